// File: doc/BRIEF.md
# SD Card Clock Generator with Flow-Control and Read-Wait Gating

This block derives the card clock of an SD/SDIO host from a fast source clock. In divided mode the card clock runs at the source frequency divided by the programmed value plus two. In bypass mode the divider is skipped and the source clock itself reaches the pin through a glitch-free gate. Next to the clock, the block gives the command and data shifters a one-cycle strobe at each card-clock rising edge, for sampling, and at each falling edge, for driving.

The clock can be paused for whole periods. This happens when the data FIFO reports that it cannot keep up, when the enable bit is cleared, and in read-wait mode. In read-wait mode the generator lets two more card-clock periods run after the period in which a block's end bit was sampled, then holds the clock low until software sets the read-wait start control. A pending command request keeps the clock running despite a read-wait stop or a FIFO stall, so the command path stays usable. While the clock is stopped for read wait, a low level on data line 1 raises a sticky card-interrupt flag.

Top module: `sd_card_clkgen`

## Requirements
- R1: After reset the card clock is low, both strobes are low, and neither the read-wait status nor the interrupt flag is set.
- R2: In divided mode one card-clock period lasts div_val+2 source cycles, and its high phase lasts (div_val+3)/2 source cycles, rounded down. A new divider value takes effect at the next period boundary.
- R3: rise_stb is high for exactly the first source cycle of each card-clock high phase, and fall_stb for exactly the first source cycle of each low phase. Neither strobe is high while the clock is paused.
- R4: While clk_en is low, the clock finishes its current period and then stays low with no strobes.
- R5: While fifo_ok is low and cmd_req is low, the clock stops at the next period boundary. It resumes at a period boundary once fifo_ok returns high. No high or low phase is ever shortened.
- R6: With bypass high, every ungated source cycle gives one card-clock pulse that follows the source clock, with both strobes high in that cycle. Gating by fifo_ok works in this mode too.
- R7: With rw_stop_mode high, a blk_end pulse (given in the cycle where rise_stb marks the end bit) lets exactly two further card-clock periods run. After them the clock stops and rw_stopped goes high.
- R8: While rw_stopped or a FIFO stall holds the clock, a high cmd_req lets the clock run. When cmd_req drops, the hold applies again.
- R9: card_irq is set only when dat1_in has been low (after a two-flop synchronizer) while rw_stopped is high. A low dat1_in outside read wait has no effect on it.
- R10: A rw_start pulse ends read wait, clears card_irq, and lets the clock resume at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card clock enable |
| div_val | input | DIV_W | Divider value; the period is div_val+2 |
| bypass | input | 1 | Drive the card clock from src_clk directly |
| rw_stop_mode | input | 1 | Read wait by stopping the clock |
| rw_start | input | 1 | Ends read wait and clears the interrupt flag |
| blk_end | input | 1 | End bit of a received block was sampled |
| fifo_ok | input | 1 | FIFO can supply or accept data |
| cmd_req | input | 1 | Command transfer needs the clock |
| dat1_in | input | 1 | Data line 1, watched for a card interrupt |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | Card-clock rising-edge strobe |
| fall_stb | output | 1 | Card-clock falling-edge strobe |
| rw_stopped | output | 1 | Clock is stopped for read wait |
| card_irq | output | 1 | Card interrupt seen during read wait |

## Verification
The assertions assume that bypass and div_val change only while the clock is idle or between periods. They also assume that blk_end arrives while a card-clock period is running, in the cycle of a rising strobe, and that rw_start is a short pulse. The bench changes bypass only after clearing clk_en and waiting out a full period. It raises blk_end only in the cycle where it has just seen rise_stb. All inputs are driven a quarter period after the rising source edge, so the falling-edge gate flop used in bypass mode sees stable values.

// File: rtl/sd_card_clkgen.sv
module sd_card_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             bypass,
  input  logic             rw_stop_mode,
  input  logic             rw_start,
  input  logic             blk_end,
  input  logic             fifo_ok,
  input  logic             cmd_req,
  input  logic             dat1_in,
  output logic             card_clk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             rw_stopped,
  output logic             card_irq
);

  localparam int PW = DIV_W + 1;

  logic          run_q, sclk_q, rise_q, fall_q, gate_n;
  logic [PW-1:0] cnt_q, per_q;
  logic          rw_pend;
  logic [1:0]    rw_left;
  logic [1:0]    d1_sync;
  logic          irq_q;

  logic          rw_hold, go, bnd, run_d, sclk_d;
  logic [PW-1:0] cnt_d, per_d;

  assign rw_hold    = rw_pend && (rw_left == 2'd0);
  assign go         = clk_en && (cmd_req || (fifo_ok && !rw_hold));
  assign bnd        = !run_q || bypass || (cnt_q == per_q - PW'(1));
  assign rw_stopped = rw_hold && !run_q;
  assign card_irq   = irq_q;

  always_comb begin
    if (bnd) begin
      run_d = go;
      cnt_d = '0;
      per_d = PW'(div_val) + PW'(2);
    end else begin
      run_d = 1'b1;
      cnt_d = cnt_q + PW'(1);
      per_d = per_q;
    end
    sclk_d = !bypass && run_d && (cnt_d < ((per_d + PW'(1)) >> 1));
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= PW'(2);
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      sclk_q <= sclk_d;
      rise_q <= sclk_d && !sclk_q;
      fall_q <= !sclk_d && sclk_q;
    end
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= bypass && go;
  end

  assign card_clk = bypass ? (src_clk && gate_n) : sclk_q;
  assign rise_stb = bypass ? run_q : rise_q;
  assign fall_stb = bypass ? run_q : fall_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_pend <= 1'b0;
      rw_left <= 2'd0;
    end else if (rw_start) begin
      rw_pend <= 1'b0;
      rw_left <= 2'd0;
    end else if (blk_end && rw_stop_mode) begin
      rw_pend <= 1'b1;
      rw_left <= 2'd2;
    end else if (bnd && run_q && rw_pend && rw_left != 2'd0) begin
      rw_left <= rw_left - 2'd1;
    end
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_sync <= 2'b11;
      irq_q   <= 1'b0;
    end else begin
      d1_sync <= {d1_sync[0], dat1_in};
      if (rw_start)                      irq_q <= 1'b0;
      else if (rw_stopped && !d1_sync[1]) irq_q <= 1'b1;
    end
  end

  logic [PW-1:0] hi_len;
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (sclk_q) hi_len <= hi_len + PW'(1);
    else             hi_len <= '0;
  end

  // R2
  hi_phase_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!bypass && $fell(sclk_q)) |-> (hi_len == ((per_q + PW'(1)) >> 1)));

  // R3
  strobe_align_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!bypass && rise_stb) |-> (card_clk && !fall_stb));

  // R4
  enable_gate_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!bypass && $rose(sclk_q)) |-> $past(clk_en));

  // R7
  rw_quiet_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    rw_stopped |-> (!rise_stb && !fall_stb));

  // R9
  irq_window_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(card_irq) |-> $past(rw_stopped));

endmodule

// File: tb/sim_sd_card_clkgen.sv
module sim_sd_card_clkgen;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       clk_en = 0, bypass = 0, rw_stop_mode = 0, rw_start = 0;
  logic       blk_end = 0, fifo_ok = 1, cmd_req = 0, dat1_in = 1;
  logic [7:0] div_val = 8'd0;
  logic       card_clk, rise_stb, fall_stb, rw_stopped, card_irq;
  int         nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  sd_card_clkgen #(.DIV_W(8)) u0 (
    .src_clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_val(div_val),
    .bypass(bypass), .rw_stop_mode(rw_stop_mode), .rw_start(rw_start),
    .blk_end(blk_end), .fifo_ok(fifo_ok), .cmd_req(cmd_req), .dat1_in(dat1_in),
    .card_clk(card_clk), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .rw_stopped(rw_stopped), .card_irq(card_irq));

  localparam int NV = 5;
  localparam int VEC [0:NV-1][0:2] = '{'{0, 2, 1}, '{1, 3, 2}, '{2, 4, 2},
                                       '{5, 7, 4}, '{8, 10, 5}};

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int found);
    found = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (rise_stb) begin found = 1; break; end
    end
  endtask

  task automatic count_act(input int n, output int act, output int rises);
    act = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (card_clk || rise_stb || fall_stb) act++;
      if (rise_stb) rises++;
    end
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int f, per, hi, act, rises, hiok, fallbad;
    step(); step(); step();
    // R1 reset state
    chk("R1 clk", card_clk, 0);
    chk("R1 stb", rise_stb | fall_stb, 0);
    chk("R1 rw", rw_stopped | card_irq, 0);
    rst_n = 1;
    count_act(5, act, rises);
    chk("R4 idle after reset", act, 0);

    clk_en = 1;
    for (int v = 0; v < NV; v++) begin
      div_val = 8'(VEC[v][0]);
      wait_rise(f); wait_rise(f);
      wait_rise(f);
      chk("R3 rise with clk high", int'(card_clk), 1);
      per = 1; hi = 1; fallbad = 0;
      for (int i = 0; i < 40; i++) begin
        step();
        if (rise_stb) break;
        per++;
        if (card_clk) hi++;
        if (fall_stb && card_clk) fallbad++;
      end
      chk("R2 period", per, VEC[v][1]);
      chk("R2 high phase", hi, VEC[v][2]);
      chk("R3 fall with clk low", fallbad, 0);
    end

    div_val = 8'd2;
    wait_rise(f); wait_rise(f);
    clk_en = 0;
    for (int i = 0; i < 6; i++) step();
    count_act(20, act, rises);
    chk("R4 disabled quiet", act, 0);
    clk_en = 1;

    wait_rise(f);
    fifo_ok = 0;
    for (int i = 0; i < 6; i++) step();
    count_act(20, act, rises);
    chk("R5 stalled quiet", act, 0);
    fifo_ok = 1;
    wait_rise(f);
    chk("R5 resume", f, 1);

    clk_en = 0;
    for (int i = 0; i < 6; i++) step();
    bypass = 1; clk_en = 1;
    step(); step();
    hiok = 0; rises = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (card_clk) hiok++;
      if (rise_stb && fall_stb) rises++;
      #10;
      if (card_clk) hiok--;
    end
    chk("R6 bypass pulses", hiok, 10);
    chk("R6 bypass strobes", rises, 10);
    fifo_ok = 0;
    step(); step();
    count_act(6, act, rises);
    chk("R6 bypass gated", act, 0);
    fifo_ok = 1;
    clk_en = 0;
    for (int i = 0; i < 4; i++) step();
    bypass = 0; clk_en = 1;

    dat1_in = 0;
    count_act(8, act, rises);
    chk("R9 no irq outside read wait", card_irq, 0);
    dat1_in = 1;

    rw_stop_mode = 1;
    wait_rise(f);
    blk_end = 1;
    step();
    blk_end = 0;
    count_act(40, act, rises);
    chk("R7 two periods after end bit", rises, 2);
    chk("R7 stopped flag", rw_stopped, 1);

    cmd_req = 1;
    count_act(12, act, rises);
    chk("R8 cmd runs clock", int'(rises > 0), 1);
    cmd_req = 0;
    for (int i = 0; i < 6; i++) step();
    count_act(12, act, rises);
    chk("R8 hold again", act, 0);
    chk("R8 still stopped", rw_stopped, 1);

    dat1_in = 0;
    for (int i = 0; i < 4; i++) step();
    chk("R9 irq set", card_irq, 1);
    dat1_in = 1;

    rw_start = 1;
    step();
    rw_start = 0;
    step();
    chk("R10 read wait cleared", rw_stopped, 0);
    chk("R10 irq cleared", card_irq, 0);
    wait_rise(f);
    chk("R10 clock resumes", f, 1);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule